// File: doc/BRIEF.md
# Stereo Fixed-Chain Biquad Equalizer

This block runs two channels of signed 24-bit PCM through a fixed equalizer chain once per audio frame. A frame begins with a one-cycle `in_valid` pulse that carries the left and right samples. The block then processes the left channel and the right channel in turn. Each channel passes through nine stages in this order: a pre-scale gain, a DC-blocking high-pass section, four general biquad sections, a de-emphasis section, a bass section and a treble section.

A single multiplier with an accumulator is shared by every stage and by both channels. It performs one product per clock. A stage that is switched off costs one clock, passes its input through unchanged and leaves its history untouched. Coefficients are loaded one word at a time through a write port. For the four general biquads, a 2-bit source field chooses one of three coefficient banks.

Each result leaves on `out_data` with a one-cycle `out_valid` strobe. The strobe comes once for the left channel and then once for the right channel in every frame. The block is meant for a host that feeds one frame at a time, with more than 100 clocks between frames.

Top module: `eq_chain`

## Requirements
- R1: After reset `out_valid` and `out_data` are 0, every biquad history word is 0, and every coefficient is 0 except each b0 slot, which holds 1.0 (0x400000). With these reset values, both channels come out equal to their inputs.
- R2: Each accepted frame gives exactly two single-cycle `out_valid` strobes: first with `out_ch`=0 (left), then with `out_ch`=1 (right). The right strobe comes no later than 100 clocks after the clock edge that accepted the frame.
- R3: Every stage result is the accumulated sum shifted right arithmetically by 22 bits and then clamped to the range -8388608 to 8388607.
- R4: When `eq_off_all` is 1 at acceptance, both outputs equal their inputs and no history word is updated.
- R5: When bit c of `chan_eq_off` is 1 at acceptance (bit 0 = left, bit 1 = right), channel c bypasses the whole chain and keeps its history. The other channel is processed normally.
- R6: The high-pass stage (stage 1) runs only when `dcblock_off` is 0.
- R7: The de-emphasis stage (stage 6) runs only when `deemph_en` is 1.
- R8: The bass and treble stages (stages 7 and 8) of channel c run only when bit c of `chan_tone_off` is 0.
- R9: `bq_source` selects the coefficients of stages 2 to 5. 00 and 11 select the user bank, 01 selects the preset bank, and 10 selects the loudness bank. The other stages always use the user bank.
- R10: A write with `coef_we`=1 stores `coef_wdata` at `coef_addr`. The user bank is at stage*5+k for stages 0 to 8, the preset bank is at 48+i*5+k and the loudness bank is at 72+i*5+k, where i = 0 to 3 is the general biquad. Here k=0 is b0, 1 is b1, 2 is b2, 3 is a1 and 4 is a2. The pre-scale stage uses only address 0. Writes to addresses 92 and above are ignored.
- R11: An active biquad stage for channel c computes y = b0*x + b1*x1 + b2*x2 + a1*y1 + a2*y2 in Q1.22 using that stage's own history for channel c. The a terms are added, so the feedback coefficients are stored already negated. The pre-scale stage computes y = b0*x.
- R12: A bypassed stage neither changes the running sample nor updates its own history.
- R13: An `in_valid` pulse that arrives while a frame is being processed is ignored.
- R14: The bypass controls and `bq_source` are captured when the frame is accepted. Changes made during processing do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle frame start pulse |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| eq_off_all | input | 1 | Bypass the whole chain on both channels |
| chan_eq_off | input | 2 | Per-channel chain bypass |
| dcblock_off | input | 1 | Bypass the high-pass stage |
| deemph_en | input | 1 | Enable the de-emphasis stage |
| chan_tone_off | input | 2 | Per-channel bass and treble bypass |
| bq_source | input | 2 | Coefficient bank for the four general biquads |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 7 | Coefficient address |
| coef_wdata | input | 24 | Coefficient value, signed Q1.22 |
| out_valid | output | 1 | Result strobe |
| out_ch | output | 1 | Channel of the current result (0 = left) |
| out_data | output | 24 | Result sample, signed |

## Verification
The assertions assume that `in_valid` is only a pulse and that any pulse during processing is dropped. They also assume that the bypass comparisons may use the sample and controls captured at acceptance, because nothing overwrites them before the strobe. The latency bound assumes the stage count is fixed. The stimulus starts each frame only after the previous right strobe, writes coefficients only while idle, and sends stray pulses and control changes only in the one scenario that checks they are ignored. An independent arithmetic model in the bench, with its own copy of the coefficients and history, supplies every expected value.

// File: rtl/eq_chain.sv
module eq_chain #(
  parameter int DW   = 24,
  parameter int CW   = 24,
  parameter int FRAC = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic                 eq_off_all,
  input  logic [1:0]           chan_eq_off,
  input  logic                 dcblock_off,
  input  logic                 deemph_en,
  input  logic [1:0]           chan_tone_off,
  input  logic [1:0]           bq_source,
  input  logic                 coef_we,
  input  logic [6:0]           coef_addr,
  input  logic signed [CW-1:0] coef_wdata,
  output logic                 out_valid,
  output logic                 out_ch,
  output logic signed [DW-1:0] out_data
);
  localparam int NST       = 9;
  localparam int NBQ       = NST - 1;
  localparam int TAPS      = 5;
  localparam int NUBQ      = 4;
  localparam int PRE_BASE  = 48;
  localparam int LOUD_BASE = PRE_BASE + 24;
  localparam int NCOEF     = LOUD_BASE + NUBQ * TAPS;
  localparam int AW        = 7;
  localparam int PW        = DW + CW;
  localparam int ACCW      = PW + 4;
  localparam logic [AW-1:0] NCOEF_A = AW'(NCOEF);
  localparam logic signed [CW-1:0] ONE = CW'(1 << FRAC);

  function automatic logic is_b0(int i);
    return (i < NST*TAPS && i % TAPS == 0) ||
           (i >= PRE_BASE && i < PRE_BASE + NUBQ*TAPS && (i - PRE_BASE) % TAPS == 0) ||
           (i >= LOUD_BASE && i < NCOEF && (i - LOUD_BASE) % TAPS == 0);
  endfunction

  logic signed [CW-1:0] coef [0:NCOEF-1];
  logic signed [DW-1:0] sx1 [0:1][0:NBQ-1];
  logic signed [DW-1:0] sx2 [0:1][0:NBQ-1];
  logic signed [DW-1:0] sy1 [0:1][0:NBQ-1];
  logic signed [DW-1:0] sy2 [0:1][0:NBQ-1];

  logic                   busy, ch;
  logic [3:0]             stage;
  logic [2:0]             tap;
  logic signed [DW-1:0]   cur, xin_l, xin_r;
  logic signed [ACCW-1:0] acc;
  logic                   c_off, c_hp, c_de;
  logic [1:0]             c_chan, c_tone, c_src;

  wire is_pre  = stage == 4'd0;
  wire is_hp   = stage == 4'd1;
  wire is_ubq  = stage >= 4'd2 && stage <= 4'd5;
  wire is_de   = stage == 4'd6;
  wire is_tone = stage >= 4'd7;
  wire chan_skip = c_off | c_chan[ch];
  wire act = !chan_skip && (is_pre || is_ubq || (is_hp && !c_hp) ||
                            (is_de && c_de) || (is_tone && !c_tone[ch]));
  wire last_tap = tap == (is_pre ? 3'd1 : 3'd5);
  wire [2:0] bq = 3'(stage - 4'd1);

  logic [AW-1:0] bq_off, cbase, cidx;
  assign bq_off = AW'(stage - 4'd2);
  always_comb begin
    if (is_ubq && c_src == 2'b01)      cbase = AW'(PRE_BASE) + bq_off * AW'(TAPS);
    else if (is_ubq && c_src == 2'b10) cbase = AW'(LOUD_BASE) + bq_off * AW'(TAPS);
    else                               cbase = AW'(stage) * AW'(TAPS);
  end
  assign cidx = cbase + AW'(tap);

  logic signed [DW-1:0] opnd;
  always_comb begin
    case (tap)
      3'd1:    opnd = sx1[ch][bq];
      3'd2:    opnd = sx2[ch][bq];
      3'd3:    opnd = sy1[ch][bq];
      3'd4:    opnd = sy2[ch][bq];
      default: opnd = cur;
    endcase
  end

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] acc_n, shifted;
  logic [ACCW-DW:0]       hi;
  logic signed [DW-1:0]   ysat;
  assign prod    = coef[cidx] * opnd;
  assign acc_n   = acc + {{(ACCW-PW){prod[PW-1]}}, prod};
  assign shifted = acc >>> FRAC;
  assign hi      = shifted[ACCW-1:DW-1];
  assign ysat    = ((&hi) | ~(|hi)) ? shifted[DW-1:0]
                 : (shifted[ACCW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) coef[i] <= is_b0(i) ? ONE : '0;
    end else if (coef_we && coef_addr < NCOEF_A) begin
      coef[coef_addr] <= coef_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ch <= 1'b0; stage <= '0; tap <= '0; acc <= '0;
      cur <= '0; xin_l <= '0; xin_r <= '0;
      c_off <= 1'b0; c_hp <= 1'b0; c_de <= 1'b0;
      c_chan <= '0; c_tone <= '0; c_src <= '0;
      out_valid <= 1'b0; out_ch <= 1'b0; out_data <= '0;
      for (int c = 0; c < 2; c++)
        for (int b = 0; b < NBQ; b++) begin
          sx1[c][b] <= '0; sx2[c][b] <= '0; sy1[c][b] <= '0; sy2[c][b] <= '0;
        end
    end else begin
      out_valid <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          busy <= 1'b1; ch <= 1'b0; stage <= '0; tap <= '0; acc <= '0;
          xin_l <= in_left; xin_r <= in_right; cur <= in_left;
          c_off <= eq_off_all; c_chan <= chan_eq_off; c_hp <= dcblock_off;
          c_de <= deemph_en; c_tone <= chan_tone_off; c_src <= bq_source;
        end
      end else if (act && !last_tap) begin
        acc <= acc_n;
        tap <= tap + 3'd1;
      end else begin
        acc <= '0;
        tap <= '0;
        if (act) begin
          cur <= ysat;
          if (!is_pre) begin
            sx1[ch][bq] <= cur;
            sx2[ch][bq] <= sx1[ch][bq];
            sy1[ch][bq] <= ysat;
            sy2[ch][bq] <= sy1[ch][bq];
          end
        end
        if (stage == 4'(NST - 1)) begin
          out_valid <= 1'b1;
          out_ch    <= ch;
          out_data  <= act ? ysat : cur;
          stage     <= '0;
          if (!ch) begin
            ch  <= 1'b1;
            cur <= xin_r;
          end else begin
            busy <= 1'b0;
          end
        end else begin
          stage <= stage + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/eq_chain_chk.sv
module eq_chain_chk #(
  parameter int DW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic                 out_ch,
  input logic signed [DW-1:0] out_data,
  input logic                 busy,
  input logic                 c_off,
  input logic [1:0]           c_chan,
  input logic signed [DW-1:0] xin_l,
  input logic signed [DW-1:0] xin_r
);
  localparam int MAXC = 2 * (2 + 8 * 6);

  logic [7:0] cnt;
  logic       exp_ch;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      exp_ch <= 1'b0;
    end else begin
      cnt <= busy ? cnt + 8'd1 : 8'd0;
      if (out_valid) exp_ch <= ~exp_ch;
    end
  end

  wire signed [DW-1:0] xin_sel = out_ch ? xin_r : xin_l;

  assert_strobe_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ch == exp_ch);
  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < 8'(MAXC));
  assert_global_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_off) |-> out_data == xin_sel);
  assert_chan_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && c_chan[out_ch]) |-> out_data == xin_sel);
  assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> ($stable(xin_l) && $stable(xin_r)));
endmodule

bind eq_chain eq_chain_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_ch(out_ch), .out_data(out_data), .busy(busy), .c_off(c_off),
  .c_chan(c_chan), .xin_l(xin_l), .xin_r(xin_r)
);

// File: tb/eq_chain_bench.sv
`timescale 1ns/1ps
module eq_chain_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, eq_off_all, dcblock_off, deemph_en, coef_we;
  logic [1:0] chan_eq_off, chan_tone_off, bq_source;
  logic signed [23:0] in_left, in_right, coef_wdata;
  logic [6:0] coef_addr;
  logic out_valid, out_ch;
  logic signed [23:0] out_data;

  eq_chain u_eq_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .eq_off_all(eq_off_all), .chan_eq_off(chan_eq_off), .dcblock_off(dcblock_off),
    .deemph_en(deemph_en), .chan_tone_off(chan_tone_off), .bq_source(bq_source),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data));

  int nchk = 0, nfail = 0;
  bit done = 0;
  int mc [0:127];
  int sx1 [0:1][0:7], sx2 [0:1][0:7], sy1 [0:1][0:7], sy2 [0:1][0:7];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int msat(longint v);
    if (v > 64'sd8388607) return 8388607;
    if (v < -64'sd8388608) return -8388608;
    return int'(v);
  endfunction

  function automatic int model(int c, int x);
    int cur, base, b, y;
    bit on;
    longint acc;
    if (eq_off_all || chan_eq_off[c]) return x;
    cur = msat((longint'(mc[0]) * x) >>> 22);
    for (int s = 1; s <= 8; s++) begin
      on = (s == 1) ? !dcblock_off : (s <= 5) ? 1'b1 : (s == 6) ? deemph_en : !chan_tone_off[c];
      if (on) begin
        if (s >= 2 && s <= 5 && bq_source == 2'b01) base = 48 + (s - 2) * 5;
        else if (s >= 2 && s <= 5 && bq_source == 2'b10) base = 72 + (s - 2) * 5;
        else base = s * 5;
        b = s - 1;
        acc = longint'(mc[base]) * cur + longint'(mc[base+1]) * sx1[c][b] +
              longint'(mc[base+2]) * sx2[c][b] + longint'(mc[base+3]) * sy1[c][b] +
              longint'(mc[base+4]) * sy2[c][b];
        y = msat(acc >>> 22);
        sx2[c][b] = sx1[c][b]; sx1[c][b] = cur;
        sy2[c][b] = sy1[c][b]; sy1[c][b] = y;
        cur = y;
      end
    end
    return cur;
  endfunction

  function automatic int rnd(int mag);
    return int'($urandom_range(0, 2 * mag)) - mag;
  endfunction

  task automatic write_coef(input int a, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = a[6:0]; coef_wdata = v[23:0];
    @(negedge clk);
    coef_we = 1'b0;
    if (a < 92) mc[a] = v;
  endtask

  task automatic run_frame(input int l, input int r, input string req, input bit disturb,
                           output int d0, output int d1);
    int e0, e1, ns, k1, k2;
    bit c0, c1;
    bit s_off, s_hp, s_de;
    logic [1:0] s_chan, s_tone, s_src;
    e0 = model(0, l);
    e1 = model(1, r);
    s_off = eq_off_all; s_hp = dcblock_off; s_de = deemph_en;
    s_chan = chan_eq_off; s_tone = chan_tone_off; s_src = bq_source;
    ns = 0; k1 = 0; k2 = 0; c0 = 0; c1 = 0; d0 = 0; d1 = 0;
    @(negedge clk);
    in_valid = 1'b1; in_left = l[23:0]; in_right = r[23:0];
    for (int k = 1; k <= 140; k++) begin
      @(negedge clk);
      if (k == 1) in_valid = 1'b0;
      if (out_valid) begin
        if (ns == 0) begin c0 = out_ch; d0 = int'(out_data); k1 = k; end
        else if (ns == 1) begin c1 = out_ch; d1 = int'(out_data); k2 = k; end
        ns++;
      end
      if (disturb && k == 5) begin
        in_valid = 1'b1; in_left = 24'sd999; in_right = -24'sd999;
        eq_off_all = 1'b1; chan_eq_off = ~s_chan; dcblock_off = ~s_hp;
        deemph_en = ~s_de; chan_tone_off = ~s_tone; bq_source = 2'b10;
      end
      if (disturb && k == 6) in_valid = 1'b0;
    end
    eq_off_all = s_off; dcblock_off = s_hp; deemph_en = s_de;
    chan_eq_off = s_chan; chan_tone_off = s_tone; bq_source = s_src;
    chk(ns == 2, "R2 strobe count", ns, 2);
    chk(c0 == 1'b0 && c1 == 1'b1, "R2 channel order", {c0, c1}, 1);
    chk(k1 < k2 && k2 <= 101, "R2 right strobe latency", k2, 101);
    chk(d0 == e0, {req, " left"}, d0, e0);
    chk(d1 == e1, {req, " right"}, d1, e1);
  endtask

  task automatic t_reset;
    int d0, d1;
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(out_data == 24'sd0, "R1 reset out_data", int'(out_data), 0);
    run_frame(1234, -5678, "R1 identity", 0, d0, d1);
    chk(d0 == 1234 && d1 == -5678, "R1 passthrough", d0, 1234);
    run_frame(8388607, -8388608, "R1 identity extremes", 0, d0, d1);
  endtask

  task automatic t_saturate;
    int d0, d1;
    write_coef(0, 8388607);
    run_frame(6291456, -6291456, "R3 clamp", 0, d0, d1);
    chk(d0 == 8388607, "R3 positive clamp", d0, 8388607);
    chk(d1 == -8388608, "R3 negative clamp", d1, -8388608);
    write_coef(0, -4194304);
    run_frame(-8388608, 100, "R3 negate most negative", 0, d0, d1);
    chk(d0 == 8388607, "R3 negate clamp", d0, 8388607);
    write_coef(0, 4194304);
  endtask

  task automatic t_chain;
    int d0, d1;
    write_coef(0, 3500000);
    for (int s = 1; s <= 8; s++) begin
      write_coef(s*5,   rnd(2097152) + 2097152);
      write_coef(s*5+1, rnd(1048576));
      write_coef(s*5+2, rnd(1048576));
      write_coef(s*5+3, rnd(1048576));
      write_coef(s*5+4, rnd(524288));
    end
    run_frame(4000000, -4000000, "R11 impulse", 0, d0, d1);
    run_frame(0, 0, "R11 ring down", 0, d0, d1);
    run_frame(0, 0, "R11 ring down 2", 0, d0, d1);
    run_frame(2000000, 2000000, "R11 step", 0, d0, d1);
    run_frame(2000000, 2000000, "R11 step hold", 0, d0, d1);
    run_frame(-7000000, 7000000, "R3 large swing", 0, d0, d1);
  endtask

  task automatic t_global;
    int d0, d1;
    eq_off_all = 1'b1;
    run_frame(777, -888, "R4 global bypass", 0, d0, d1);
    chk(d0 == 777 && d1 == -888, "R4 outputs equal inputs", d1, -888);
    run_frame(-5000000, 3000000, "R4 global bypass 2", 0, d0, d1);
    eq_off_all = 1'b0;
    run_frame(1000, 2000, "R12 history kept after bypass", 0, d0, d1);
  endtask

  task automatic t_chan;
    int d0, d1;
    chan_eq_off = 2'b01;
    run_frame(31337, 500000, "R5 left bypass", 0, d0, d1);
    chk(d0 == 31337, "R5 left equals input", d0, 31337);
    chan_eq_off = 2'b10;
    run_frame(500000, -31337, "R5 right bypass", 0, d0, d1);
    chk(d1 == -31337, "R5 right equals input", d1, -31337);
    chan_eq_off = 2'b00;
    run_frame(123456, 654321, "R12 both active again", 0, d0, d1);
  endtask

  task automatic t_stages;
    int d0, d1;
    dcblock_off = 1'b1;
    run_frame(1500000, -1500000, "R6 high-pass off", 0, d0, d1);
    dcblock_off = 1'b0;
    run_frame(1500000, -1500000, "R6 high-pass on", 0, d0, d1);
    deemph_en = 1'b0;
    run_frame(-900000, 900000, "R7 de-emphasis off", 0, d0, d1);
    deemph_en = 1'b1;
    run_frame(-900000, 900000, "R7 de-emphasis on", 0, d0, d1);
    chan_tone_off = 2'b10;
    run_frame(2500000, 2500000, "R8 right tone off", 0, d0, d1);
    chan_tone_off = 2'b01;
    run_frame(2500000, 2500000, "R8 left tone off", 0, d0, d1);
    chan_tone_off = 2'b00;
    run_frame(-2500000, 100, "R8 tone on", 0, d0, d1);
  endtask

  task automatic t_modes;
    int d0, d1;
    for (int i = 0; i < 4; i++) begin
      write_coef(48 + i*5, 4194304 - 300000 * (i + 1));
      write_coef(49 + i*5, rnd(800000));
      write_coef(53 + i*5, rnd(400000));
      write_coef(72 + i*5, 4194304 + 200000 * (i + 1));
      write_coef(74 + i*5, rnd(800000));
      write_coef(75 + i*5, rnd(400000));
    end
    bq_source = 2'b01;
    run_frame(3000000, -2000000, "R9 preset bank", 0, d0, d1);
    bq_source = 2'b10;
    run_frame(3000000, -2000000, "R9 loudness bank", 0, d0, d1);
    bq_source = 2'b11;
    run_frame(3000000, -2000000, "R9 code 11 user bank", 0, d0, d1);
    bq_source = 2'b00;
    run_frame(-1000000, 1000000, "R9 user bank", 0, d0, d1);
  endtask

  task automatic t_unmapped;
    int d0, d1;
    for (int a = 92; a < 128; a += 5) write_coef(a, -8388608);
    for (int a = 1; a <= 4; a++) write_coef(a, 8388607);
    write_coef(45, 8388607);
    write_coef(70, 8388607);
    run_frame(2222222, -1111111, "R10 unused addresses", 0, d0, d1);
    write_coef(0, 2097152);
    run_frame(2222222, -1111111, "R10 pre-scale rewrite", 0, d0, d1);
  endtask

  task automatic t_disturb;
    int d0, d1;
    chan_tone_off = 2'b00; dcblock_off = 1'b0; deemph_en = 1'b1; bq_source = 2'b01;
    run_frame(1800000, -2600000, "R13 R14 stray pulse and control change", 1, d0, d1);
    bq_source = 2'b00;
    run_frame(400000, 400000, "R13 no extra frame", 0, d0, d1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
    eq_off_all = 1'b0; chan_eq_off = 2'b00; dcblock_off = 1'b0; deemph_en = 1'b1;
    chan_tone_off = 2'b00; bq_source = 2'b00;
    coef_we = 1'b0; coef_addr = '0; coef_wdata = '0;
    for (int i = 0; i < 128; i++)
      mc[i] = ((i < 45 && i % 5 == 0) || (i >= 48 && i < 68 && (i - 48) % 5 == 0) ||
               (i >= 72 && i < 92 && (i - 72) % 5 == 0)) ? 4194304 : 0;
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 8; b++) begin
        sx1[c][b] = 0; sx2[c][b] = 0; sy1[c][b] = 0; sy2[c][b] = 0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_saturate;
    t_chain;
    t_global;
    t_chan;
    t_stages;
    t_modes;
    t_unmapped;
    t_disturb;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule